// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is a two-wire bus target that sits in front of a byte-wide on-chip memory of 4096 locations. A host selects it with a control byte. It then either streams bytes into the array or reads bytes back out of it. The bus pins are open-drain, so the block sees each line as an input and drives only a pull-low enable on the data line. Both lines are resynchronised to the system clock, and bus events are recognised from edges of those synchronised copies.

A 12-bit address pointer is held between transactions. A write whose address phase is followed directly by a stop only moves the pointer. Data bytes that follow an address are written to consecutive locations. A read may start at a freshly loaded address: the host sends a write control byte and the address, then a repeated start and a read control byte. A read may also start at the current pointer. During a read, every host acknowledge requests the next byte, and the pointer wraps from the last location back to the first.

Control states: `ST_IDLE` (bus free), `ST_CTRL` (receive control byte), `ST_CTRL_ACK` (acknowledge the control byte), `ST_ADDR_HI` / `ST_ADDR_HI_ACK` (upper address byte), `ST_ADDR_LO` / `ST_ADDR_LO_ACK` (lower address byte), `ST_WDATA` / `ST_WDATA_ACK` (write byte), `ST_RDATA` (shift a byte out), `ST_RDATA_ACK` (sample the host acknowledge), and `ST_IGNORE` (stay silent until the next start or stop).

Transitions:
- Any state goes to `ST_CTRL` on a start and to `ST_IDLE` on a stop.
- `ST_CTRL` goes to `ST_CTRL_ACK` when the control byte matches. It goes to `ST_IGNORE` when it does not.
- `ST_CTRL_ACK` goes to `ST_RDATA` for a read and to `ST_ADDR_HI` for a write.
- `ST_ADDR_HI` goes to `ST_ADDR_HI_ACK` when the upper nibble is zero. Otherwise it goes to `ST_IGNORE`.
- `ST_ADDR_HI_ACK` goes to `ST_ADDR_LO`.
- `ST_ADDR_LO` goes to `ST_ADDR_LO_ACK`, then to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WDATA_ACK`, then back to `ST_WDATA`.
- `ST_RDATA` goes to `ST_RDATA_ACK`.
- `ST_RDATA_ACK` goes back to `ST_RDATA` when the host acknowledges. It goes to `ST_IGNORE` when the host does not.

Top module: `i2c_mem_target`

## Requirements
- R1: A control byte is accepted, and acknowledged by pulling SDA low during the ninth clock, only if all three fields match: bits 7..4 equal 1010, bits 3..1 equal `dev_sel`, and bit 0 gives the direction (0 = write, 1 = read).
- R2: If the control byte does not match, no acknowledge is given. SDA stays released and the bus is ignored until the next start, and the pointer is left unchanged.
- R3: A start is SDA falling while SCL is high, and it restarts control-byte reception from any state. A stop is SDA rising while SCL is high, and it returns the block to idle with SDA released.
- R4: The address is sent upper byte first, then lower byte. If the upper byte has any of bits 7..4 set, it is not acknowledged and the rest of the transaction is ignored.
- R5: In a write, each data byte after the address is stored at the pointer and acknowledged, and the pointer then advances by one.
- R6: A write made of only the control byte and the two address bytes, followed by a stop, loads the pointer and writes nothing.
- R7: A random read sends a write control byte and the address, then a repeated start and a read control byte. It returns the byte at that address, most significant bit first.
- R8: During a read, a host acknowledge on the ninth clock makes the block send the byte at the next address. A missing acknowledge makes it release SDA and wait for a stop.
- R9: The pointer advances by one after every byte written or sent. A read with no address phase returns the byte at the last address accessed plus one.
- R10: The pointer wraps from 0xFFF to 0x000. This applies to consecutive writes and to an acknowledged sequential read.
- R11: SDA is changed only while SCL is low, and host bits are sampled on the rising edge of SCL.
- R12: After reset, SDA is released and the pointer is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull the data line low when 1 |
| dev_sel | input | 3 | Strap value compared against the control byte select bits |

## Verification
Two functions meet in one cycle: the pointer increment that ends a read byte, and the wrap from the last location. In that same cycle the fetch of the following byte also uses the wrapped value. The bench provokes this with a write that runs across 0xFFF into 0x000, followed by an acknowledged sequential read that starts at 0xFFF. The check passes only if the second byte read back is the one stored at 0x000. A second meeting point is a repeated start in the middle of an address phase. It must discard the partial address and leave the pointer as it was, and a current-address read that follows shows whether it did.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR_HI,
        ST_ADDR_HI_ACK,
        ST_ADDR_LO,
        ST_ADDR_LO_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } tgt_state_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic scl_prev;
    logic sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s    = scl_pipe[STAGES-1];
    assign sda_s    = sda_pipe[STAGES-1];
    assign scl_rise = scl_s & ~scl_prev;
    assign scl_fall = ~scl_s & scl_prev;
    // bus events: data line edge while clock is high on both samples
    assign start_ev = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_ev  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2cm_array.sv
module i2cm_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [SEL_W-1:0]  dev_sel,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              sda_oe
);
    localparam int HI_W  = ADDR_W - BYTE_W;
    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    tgt_state_t        state, state_nx;
    logic [BYTE_W-1:0] shreg, shreg_nx;
    logic [CNT_W-1:0]  bitcnt, bitcnt_nx;
    logic [ADDR_W-1:0] ptr, ptr_nx;
    logic [HI_W-1:0]   addr_hi, addr_hi_nx;
    logic              rw, rw_nx;
    logic              host_ack, host_ack_nx;
    logic              oe_nx;
    logic              byte_done;
    logic              ctrl_match;
    logic              hi_ok;

    assign byte_done  = scl_fall && (bitcnt == LAST_BIT);
    assign ctrl_match = (shreg[7:4] == DEV_TYPE) && (shreg[SEL_W:1] == dev_sel);
    assign hi_ok      = (shreg[BYTE_W-1:HI_W] == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            ptr      <= '0;
            addr_hi  <= '0;
            rw       <= 1'b0;
            host_ack <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            state    <= state_nx;
            shreg    <= shreg_nx;
            bitcnt   <= bitcnt_nx;
            ptr      <= ptr_nx;
            addr_hi  <= addr_hi_nx;
            rw       <= rw_nx;
            host_ack <= host_ack_nx;
            sda_oe   <= oe_nx;
        end
    end

    // next-state and output logic
    always_comb begin
        state_nx    = state;
        shreg_nx    = shreg;
        bitcnt_nx   = bitcnt;
        ptr_nx      = ptr;
        addr_hi_nx  = addr_hi;
        rw_nx       = rw;
        host_ack_nx = host_ack;
        oe_nx       = sda_oe;
        mem_we      = 1'b0;
        mem_addr    = ptr;
        mem_wdata   = shreg;

        if (start_ev) begin
            state_nx  = ST_CTRL;
            bitcnt_nx = '0;
            oe_nx     = 1'b0;
        end else if (stop_ev) begin
            state_nx  = ST_IDLE;
            oe_nx     = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: begin
                    oe_nx = 1'b0;
                end
                ST_CTRL, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg_nx  = {shreg[BYTE_W-2:0], sda_s};
                        bitcnt_nx = bitcnt + 1'b1;
                    end else if (byte_done) begin
                        bitcnt_nx = '0;
                        oe_nx     = 1'b1;
                        unique case (state)
                            ST_CTRL: begin
                                if (ctrl_match) begin
                                    rw_nx    = shreg[0];
                                    state_nx = ST_CTRL_ACK;
                                end else begin
                                    oe_nx    = 1'b0;
                                    state_nx = ST_IGNORE;
                                end
                            end
                            ST_ADDR_HI: begin
                                if (hi_ok) begin
                                    addr_hi_nx = shreg[HI_W-1:0];
                                    state_nx   = ST_ADDR_HI_ACK;
                                end else begin
                                    oe_nx    = 1'b0;
                                    state_nx = ST_IGNORE;
                                end
                            end
                            ST_ADDR_LO: begin
                                ptr_nx   = {addr_hi, shreg};
                                state_nx = ST_ADDR_LO_ACK;
                            end
                            default: begin
                                mem_we   = 1'b1;
                                ptr_nx   = ptr + 1'b1;
                                state_nx = ST_WDATA_ACK;
                            end
                        endcase
                    end
                end
                ST_CTRL_ACK, ST_ADDR_HI_ACK, ST_ADDR_LO_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        bitcnt_nx = '0;
                        oe_nx     = 1'b0;
                        unique case (state)
                            ST_CTRL_ACK: begin
                                if (rw) begin
                                    shreg_nx = rd_data;
                                    oe_nx    = ~rd_data[BYTE_W-1];
                                    state_nx = ST_RDATA;
                                end else begin
                                    state_nx = ST_ADDR_HI;
                                end
                            end
                            ST_ADDR_HI_ACK: state_nx = ST_ADDR_LO;
                            default:        state_nx = ST_WDATA;
                        endcase
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bitcnt_nx = bitcnt + 1'b1;
                    end else if (byte_done) begin
                        oe_nx     = 1'b0;
                        ptr_nx    = ptr + 1'b1;
                        bitcnt_nx = '0;
                        state_nx  = ST_RDATA_ACK;
                    end else if (scl_fall) begin
                        shreg_nx = {shreg[BYTE_W-2:0], 1'b0};
                        oe_nx    = ~shreg[BYTE_W-2];
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        host_ack_nx = ~sda_s;
                    end else if (scl_fall) begin
                        if (host_ack) begin
                            shreg_nx = rd_data;
                            oe_nx    = ~rd_data[BYTE_W-1];
                            state_nx = ST_RDATA;
                        end else begin
                            oe_nx    = 1'b0;
                            state_nx = ST_IGNORE;
                        end
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    assert_start_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_CTRL) && !sda_oe);
    assert_stop_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE) && !sda_oe);
    assert_pull_only_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
    assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA_ACK && $past(state) == ST_RDATA) |-> ptr == ADDR_W'($past(ptr) + 1'b1));
    assert_ignore_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe);
    assert_write_in_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (state == ST_WDATA_ACK) && sda_oe);
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
    parameter int ADDR_W      = 12,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [SEL_W-1:0] dev_sel
);
    localparam int DATA_W = i2cm_pkg::BYTE_W;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2cm_ctrl #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .dev_sel   (dev_sel),
        .rd_data   (mem_rdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sda_oe    (sda_oe)
    );

    i2cm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (mem_addr),
        .rdata (mem_rdata)
    );

    assert_reset_released_R12: assert property (@(posedge clk)
        !rst_n |=> !sda_oe);
endmodule

// File: tb/i2c_mem_target_bench.sv
module i2c_mem_target_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HP = 8;
    localparam logic [2:0] SEL = 3'b101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [2:0] dev_sel = SEL;
    int         total = 0;
    int         bad = 0;
    int         r11_viol = 0;
    logic       oe_prev = 1'b0;
    logic       finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_mem_target u_i2c_mem_target (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .dev_sel (dev_sel)
    );

    // R11 monitor: data drive must not move while the clock line is high
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_m) r11_viol++;
        oe_prev <= sda_oe;
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        wait_clks(2);
        sda_m = 1'b1; wait_clks(HP);
        scl_m = 1'b1; wait_clks(HP);
        sda_m = 1'b0; wait_clks(HP);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clks(2);
        sda_m = 1'b0; wait_clks(HP);
        scl_m = 1'b1; wait_clks(HP);
        sda_m = 1'b1; wait_clks(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            wait_clks(2);
            sda_m = b[i]; wait_clks(HP);
            scl_m = 1'b1; wait_clks(HP);
            scl_m = 1'b0;
        end
        wait_clks(2);
        sda_m = 1'b1; wait_clks(HP);
        scl_m = 1'b1; wait_clks(HP/2);
        acked = ~sda_line; wait_clks(HP/2);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        d = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_clks(HP);
            scl_m = 1'b1; wait_clks(HP/2);
            d = {d[6:0], sda_line}; wait_clks(HP/2);
            scl_m = 1'b0;
        end
        wait_clks(2);
        sda_m = ~give_ack; wait_clks(HP);
        scl_m = 1'b1; wait_clks(HP);
        scl_m = 1'b0; wait_clks(2);
        sda_m = 1'b1;
    endtask

    task automatic addr_phase(input logic [11:0] a, input string req);
        logic ak;
        bus_start();
        send_byte({4'b1010, SEL, 1'b0}, ak);
        check(ak, "R1 control write ack", ak, 1);
        send_byte({4'b0000, a[11:8]}, ak);
        check(ak, {req, " high address ack"}, ak, 1);
        send_byte(a[7:0], ak);
        check(ak, {req, " low address ack"}, ak, 1);
    endtask

    task automatic t_write(input logic [11:0] a, input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2, input logic [7:0] d3, input int n);
        logic ak;
        logic [7:0] dv [4];
        dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
        addr_phase(a, "R5");
        for (int i = 0; i < n; i++) begin
            send_byte(dv[i], ak);
            check(ak, "R5 data byte ack", ak, 1);
        end
        bus_stop();
    endtask

    task automatic t_random_read(input logic [11:0] a, input logic [7:0] exp, input string req);
        logic ak;
        logic [7:0] d;
        addr_phase(a, req);
        bus_start();
        send_byte({4'b1010, SEL, 1'b1}, ak);
        check(ak, "R1 control read ack", ak, 1);
        recv_byte(1'b0, d);
        check(d == exp, req, d, exp);
        bus_stop();
    endtask

    task automatic t_current_read(input logic [7:0] exp, input string req);
        logic ak;
        logic [7:0] d;
        bus_start();
        send_byte({4'b1010, SEL, 1'b1}, ak);
        check(ak, "R1 current read ack", ak, 1);
        recv_byte(1'b0, d);
        check(d == exp, req, d, exp);
        bus_stop();
    endtask

    task automatic t_seq_read(input logic [11:0] a, input logic [7:0] e0, input logic [7:0] e1,
                              input logic [7:0] e2, input int n, input string req);
        logic ak;
        logic [7:0] d;
        logic [7:0] ev [3];
        ev[0] = e0; ev[1] = e1; ev[2] = e2;
        addr_phase(a, req);
        bus_start();
        send_byte({4'b1010, SEL, 1'b1}, ak);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n-1, d);
            check(d == ev[i], req, d, ev[i]);
        end
        wait_clks(HP);
        check(!sda_oe, "R8 released after no-ack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_addr_only();
        addr_phase(12'hFFE, "R6");
        bus_stop();
        t_current_read(8'h11, "R6 pointer load by address-only write");
    endtask

    task automatic t_mismatch();
        logic ak;
        bus_start();
        send_byte({4'b1010, 3'b000, 1'b0}, ak);
        check(!ak, "R2 wrong select not acked", ak, 0);
        send_byte(8'h00, ak);
        check(!ak, "R2 following byte ignored", ak, 0);
        bus_stop();
        t_current_read(8'h22, "R2 pointer unchanged after mismatch");
    endtask

    task automatic t_hi_nibble();
        logic ak;
        bus_start();
        send_byte({4'b1010, SEL, 1'b0}, ak);
        send_byte(8'h10, ak);
        check(!ak, "R4 nonzero upper nibble not acked", ak, 0);
        send_byte(8'h55, ak);
        check(!ak, "R4 rest ignored", ak, 0);
        bus_stop();
        t_current_read(8'h33, "R4 pointer unchanged");
    endtask

    task automatic t_restart_mid_addr();
        logic ak;
        bus_start();
        send_byte({4'b1010, SEL, 1'b0}, ak);
        send_byte(8'h01, ak);
        check(ak, "R3 high byte ack before restart", ak, 1);
        t_current_read(8'h44, "R3 restart discards partial address");
    endtask

    task automatic t_reset_mid();
        rst_n = 1'b0; wait_clks(3);
        check(!sda_oe, "R12 released in reset", sda_oe, 0);
        rst_n = 1'b1; wait_clks(3);
        t_current_read(8'h33, "R12 pointer zero after reset");
    endtask

    initial begin
        wait_clks(3);
        check(!sda_oe, "R12 released at reset", sda_oe, 0);
        rst_n = 1'b1;
        wait_clks(4);
        t_write(12'h123, 8'hA5, 8'h3C, 8'hF0, 8'h00, 3);
        t_random_read(12'h124, 8'h3C, "R7 random read");
        t_current_read(8'hF0, "R9 current address read");
        t_seq_read(12'h123, 8'hA5, 8'h3C, 8'hF0, 3, "R8 sequential read");
        t_write(12'hFFE, 8'h11, 8'h22, 8'h33, 8'h44, 4);
        t_seq_read(12'hFFF, 8'h22, 8'h33, 8'h00, 2, "R10 wrap during read");
        t_addr_only();
        t_mismatch();
        t_hi_nibble();
        t_restart_mid_addr();
        check(r11_viol == 0, "R11 drive changed while SCL high", r11_viol, 0);
        t_reset_mid();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule